// File: doc/BRIEF.md
# Mode-Selectable Inverting Bidirectional Transceiver Core

This block is the logic core of a byte-wide bidirectional transceiver. It sits between a parallel A side and a shared, open-collector B bus. The A side has a separate input bus and output bus. Data crossing the block in either direction is always inverted. Each direction has its own storage element and its own clock/enable pin. A two-bit select chooses that element's behaviour at run time: a plain pass-through, a rising-edge register, or a level-sensitive latch that is open while its pin is high.

The B bus is not driven as a value. The block only tells each pin whether to pull low or to let go, and reads back the resolved wired level. The A output bus comes with a per-bit enable that an outer pad ring turns into a three-state driver.

A loopback control feeds the stored A-to-B value, without inverting it, into the B-to-A element in place of the bus data. A word can then make a round trip from the A input to the A output without touching the bus. The output enables act only on the drivers. Both storage elements keep loading or holding while their outputs are off.

Top module: `dual_path_xcvr`

## Requirements
- R1: An active-low asynchronous reset clears every register and latch to zero. While reset is held, register mode therefore gives aOut = all ones and bDriveLow = all zeros with the B side enabled.
- R2: In buffer mode (select 00) the element passes its input straight through. A-to-B gives bus level ~aIn, and B-to-A gives aOut = ~bBusIn.
- R3: In register mode (select 01) a direction's element loads on the rising edge of its own clock only (clkAB for A-to-B, clkBA for B-to-A). Between those edges it holds, whatever its input does or the other clock does.
- R4: In latch mode (select 10) the element follows its input while its clock pin is high and keeps the last value while the pin is low.
- R5: With loopback high, the B-to-A element takes the A-to-B element's output, uninverted, in place of bBusIn. aOut is then the inverse of the A-to-B element output, and the B bus has no effect.
- R6: aOutEn is all ones while oeA is high and all zeros while oeA is low.
- R7: The B side pulls low only when bEnAct = 1 and bEnInh = 0. With any other pair, bDriveLow is all zeros and bRelease is all ones.
- R8: The B bus is open-collector. When the B side is enabled, bit i of bDriveLow is 1 exactly where the bus level (the inverted A-to-B element output) is 0. bRelease is always the bitwise complement of bDriveLow.
- R9: Registers and latches keep loading and holding while oeA is low or the B side is disabled. Data stored then shows on the outputs once they are enabled.
- R10: The B-to-A path reads bBusIn as the resolved wired bus: a bit is 0 where any device, this one included, pulls low, and 1 where all release.
- R11: Select code 11 behaves exactly like buffer mode (00) in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset of all storage |
| modeAB | input | 2 | A-to-B element select: 00 buffer, 01 register, 10 latch, 11 buffer |
| modeBA | input | 2 | B-to-A element select, same encoding |
| clkAB | input | 1 | A-to-B register clock / latch open-high enable |
| clkBA | input | 1 | B-to-A register clock / latch open-high enable |
| loopback | input | 1 | High: B-to-A element fed from A-to-B element output |
| aIn | input | W | A-side input bus |
| oeA | input | 1 | A output enable, active high |
| aOut | output | W | A-side output data (inverted B-to-A element output) |
| aOutEn | output | W | Per-bit A output driver enable |
| bEnAct | input | 1 | B enable, must be high to drive |
| bEnInh | input | 1 | B inhibit, must be low to drive |
| bBusIn | input | W | Resolved wired level of the B bus |
| bDriveLow | output | W | Per-bit pull-low request for the B bus |
| bRelease | output | W | Per-bit release indication, complement of bDriveLow |

## Verification
Each direction is run in all four select codes with bytes chosen so that set bits and cleared bits both occur. This separates a missing inversion from a missing drive. In register and latch modes the bench moves the data between clock events and pulses the wrong direction's clock, to show that only the correct edge or level changes the stored value. The B bus is modelled as a wired-AND of an external value and the block's own pulls. Overlapping patterns then show whether the B-to-A path reads the resolved level. The bench also tries every pair of B enable inputs. Loopback runs use a bus value opposite to the A data, so reading the bus by mistake is seen at once.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    ELEM_BUF = 2'b00,
    ELEM_REG = 2'b01,
    ELEM_LAT = 2'b10,
    ELEM_ALT = 2'b11
  } elem_sel_e;

  typedef struct packed {
    elem_sel_e abSel;
    elem_sel_e baSel;
    logic      loopSel;
    logic      aDrive;
    logic      bDrive;
  } xcvr_strobe_t;

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic [SEL_W-1:0] modeAB,
  input  logic [SEL_W-1:0] modeBA,
  input  logic             loopback,
  input  logic             oeA,
  input  logic             bEnAct,
  input  logic             bEnInh,
  output xcvr_strobe_t     strobe
);

  function automatic elem_sel_e decodeSel(input logic [SEL_W-1:0] code);
    case (code)
      2'b01:   decodeSel = ELEM_REG;
      2'b10:   decodeSel = ELEM_LAT;
      default: decodeSel = ELEM_BUF; // 00 and the spare 11 code
    endcase
  endfunction

  always_comb begin
    strobe.abSel   = decodeSel(modeAB);
    strobe.baSel   = decodeSel(modeBA);
    strobe.loopSel = loopback;
    strobe.aDrive  = oeA;
    strobe.bDrive  = bEnAct & ~bEnInh;
  end

endmodule

// File: rtl/xcvr_stage.sv
module xcvr_stage
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic      rstN,
  input  logic      clkEn,
  input  elem_sel_e sel,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] regQ;
  logic [W-1:0] latQ;

  // Edge storage: loads on every rising edge, whatever the select.
  always_ff @(posedge clkEn or negedge rstN) begin
    if (!rstN) regQ <= '0;
    else       regQ <= d;
  end

  // Level storage: open while clkEn is high.
  always_latch begin
    if (!rstN)      latQ = '0;
    else if (clkEn) latQ = d;
  end

  always_comb begin
    case (sel)
      ELEM_REG: q = regQ;
      ELEM_LAT: q = latQ;
      default:  q = d;
    endcase
  end

endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rstN,
  input  logic         clkAB,
  input  logic         clkBA,
  input  xcvr_strobe_t strobe,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bBusIn,
  output logic [W-1:0] aOut,
  output logic [W-1:0] aOutEn,
  output logic [W-1:0] bDriveLow,
  output logic [W-1:0] bRelease
);

  logic [W-1:0] abQ;
  logic [W-1:0] baD;
  logic [W-1:0] baQ;

  xcvr_stage #(.W(W)) abStage (
    .rstN (rstN),
    .clkEn(clkAB),
    .sel  (strobe.abSel),
    .d    (aIn),
    .q    (abQ)
  );

  assign baD = strobe.loopSel ? abQ : bBusIn;

  xcvr_stage #(.W(W)) baStage (
    .rstN (rstN),
    .clkEn(clkBA),
    .sel  (strobe.baSel),
    .d    (baD),
    .q    (baQ)
  );

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      // Bus level is ~abQ; pull low where that level is 0.
      assign bDriveLow[i] = strobe.bDrive & abQ[i];
      assign bRelease[i]  = ~bDriveLow[i];
      assign aOut[i]      = ~baQ[i];
      assign aOutEn[i]    = strobe.aDrive;
    end
  endgenerate

endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             rstN,
  input  logic [SEL_W-1:0] modeAB,
  input  logic [SEL_W-1:0] modeBA,
  input  logic             clkAB,
  input  logic             clkBA,
  input  logic             loopback,
  input  logic [W-1:0]     aIn,
  input  logic             oeA,
  output logic [W-1:0]     aOut,
  output logic [W-1:0]     aOutEn,
  input  logic             bEnAct,
  input  logic             bEnInh,
  input  logic [W-1:0]     bBusIn,
  output logic [W-1:0]     bDriveLow,
  output logic [W-1:0]     bRelease
);

  xcvr_strobe_t strobe;

  xcvr_ctrl ctrl (
    .modeAB  (modeAB),
    .modeBA  (modeBA),
    .loopback(loopback),
    .oeA     (oeA),
    .bEnAct  (bEnAct),
    .bEnInh  (bEnInh),
    .strobe  (strobe)
  );

  xcvr_datapath #(.W(W)) datapath (
    .rstN     (rstN),
    .clkAB    (clkAB),
    .clkBA    (clkBA),
    .strobe   (strobe),
    .aIn      (aIn),
    .bBusIn   (bBusIn),
    .aOut     (aOut),
    .aOutEn   (aOutEn),
    .bDriveLow(bDriveLow),
    .bRelease (bRelease)
  );

endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 8
) (
  input logic         rstN,
  input logic [1:0]   modeAB,
  input logic [1:0]   modeBA,
  input logic         clkAB,
  input logic         clkBA,
  input logic         loopback,
  input logic [W-1:0] aIn,
  input logic         oeA,
  input logic [W-1:0] aOut,
  input logic [W-1:0] aOutEn,
  input logic         bEnAct,
  input logic         bEnInh,
  input logic [W-1:0] bBusIn,
  input logic [W-1:0] bDriveLow
);

  logic driveOk;
  assign driveOk = bEnAct & ~bEnInh;

  // R7
  b_quiet_chk: assert property (@(posedge clkAB) disable iff (!rstN)
    !driveOk |-> (bDriveLow == '0));

  // R6
  a_enable_chk: assert property (@(posedge clkBA) disable iff (!rstN)
    aOutEn == (oeA ? {W{1'b1}} : {W{1'b0}}));

  // R2
  ab_buffer_chk: assert property (@(posedge clkAB) disable iff (!rstN)
    (modeAB == 2'b00 && driveOk) |-> (bDriveLow == aIn));

  // R3
  ab_register_chk: assert property (@(posedge clkAB) disable iff (!rstN)
    (modeAB == 2'b01) |=>
      (!(modeAB == 2'b01 && driveOk) || bDriveLow == $past(aIn)));

  // R10
  ba_bus_read_chk: assert property (@(posedge clkBA) disable iff (!rstN)
    (modeBA == 2'b00 && !loopback) |-> (aOut == ~bBusIn));

  // R5
  loop_round_trip_chk: assert property (@(posedge clkBA) disable iff (!rstN)
    (loopback && modeAB == 2'b00 && modeBA == 2'b00) |-> (aOut == ~aIn));

endmodule

bind dual_path_xcvr xcvr_chk #(.W(W)) chkInst (
  .rstN     (rstN),
  .modeAB   (modeAB),
  .modeBA   (modeBA),
  .clkAB    (clkAB),
  .clkBA    (clkBA),
  .loopback (loopback),
  .aIn      (aIn),
  .oeA      (oeA),
  .aOut     (aOut),
  .aOutEn   (aOutEn),
  .bEnAct   (bEnAct),
  .bEnInh   (bEnInh),
  .bBusIn   (bBusIn),
  .bDriveLow(bDriveLow)
);

// File: tb/dual_path_xcvr_test.sv
`timescale 1ns/1ps
module dual_path_xcvr_test;

  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic clk = 1'b0;
  always #(HALF) clk = ~clk;

  logic         rstN = 1'b0;
  logic [1:0]   modeAB = 2'b01, modeBA = 2'b01;
  logic         clkAB = 1'b0, clkBA = 1'b0;
  logic         loopback = 1'b0;
  logic [W-1:0] aIn = '0;
  logic         oeA = 1'b1;
  logic         bEnAct = 1'b1, bEnInh = 1'b0;
  logic [W-1:0] bExt = '1;
  logic [W-1:0] aOut, aOutEn, bDriveLow, bRelease, bBusIn;

  // Wired-AND bus: low where anyone pulls low.
  assign bBusIn = bExt & ~bDriveLow;

  dual_path_xcvr #(.W(W)) uut (
    .rstN(rstN), .modeAB(modeAB), .modeBA(modeBA), .clkAB(clkAB), .clkBA(clkBA),
    .loopback(loopback), .aIn(aIn), .oeA(oeA), .aOut(aOut), .aOutEn(aOutEn),
    .bEnAct(bEnAct), .bEnInh(bEnInh), .bBusIn(bBusIn), .bDriveLow(bDriveLow),
    .bRelease(bRelease)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    #(HALF);
  endtask

  task automatic pulseAB();
    clkAB = 1'b1; settle(); clkAB = 1'b0; settle();
  endtask

  task automatic pulseBA();
    clkBA = 1'b1; settle(); clkBA = 1'b0; settle();
  endtask

  task automatic test_reset();
    rstN = 1'b0; modeAB = 2'b01; modeBA = 2'b01; aIn = 8'h5A; bExt = '1;
    settle();
    pulseAB();
    chk("R1 aOut in reset", aOut, 8'hFF);
    chk("R1 bDriveLow in reset", bDriveLow, 8'h00);
    rstN = 1'b1; settle();
  endtask

  task automatic test_buffer();
    modeAB = 2'b00; modeBA = 2'b00; loopback = 1'b0; bEnAct = 1'b1; bEnInh = 1'b0;
    bExt = 8'hFF; aIn = 8'h3C; settle();
    chk("R2 A-to-B pull pattern", bDriveLow, 8'h3C);
    chk("R8 release complement", bRelease, 8'hC3);
    chk("R10 own pull read back", aOut, 8'h3C);
    bExt = 8'hF0; settle();
    chk("R10 wired-AND read", aOut, 8'h3F);
    modeAB = 2'b11; modeBA = 2'b11; bExt = 8'hFF; aIn = 8'h81; settle();
    chk("R11 code 11 A-to-B", bDriveLow, 8'h81);
    bEnAct = 1'b0; bExt = 8'h96; settle();
    chk("R11 code 11 B-to-A", aOut, 8'h69);
    modeBA = 2'b00; bExt = 8'h0F; settle();
    chk("R2 B-to-A inverted", aOut, 8'hF0);
  endtask

  task automatic test_b_enables();
    modeAB = 2'b00; aIn = 8'hFF; bExt = 8'hFF;
    bEnAct = 1'b0; bEnInh = 1'b0; settle();
    chk("R7 act=0 inh=0 drive", bDriveLow, 8'h00);
    chk("R7 act=0 inh=0 release", bRelease, 8'hFF);
    bEnAct = 1'b1; bEnInh = 1'b1; settle();
    chk("R7 act=1 inh=1 drive", bDriveLow, 8'h00);
    bEnAct = 1'b0; bEnInh = 1'b1; settle();
    chk("R7 act=0 inh=1 drive", bDriveLow, 8'h00);
    bEnAct = 1'b1; bEnInh = 1'b0; settle();
    chk("R7 act=1 inh=0 drive", bDriveLow, 8'hFF);
  endtask

  task automatic test_register();
    modeAB = 2'b01; modeBA = 2'b00; loopback = 1'b0; bEnAct = 1'b1; bEnInh = 1'b0;
    aIn = 8'h12; settle(); pulseAB();
    chk("R3 A-to-B load on clkAB", bDriveLow, 8'h12);
    aIn = 8'h34; settle();
    chk("R3 A-to-B hold between edges", bDriveLow, 8'h12);
    pulseBA();
    chk("R3 A-to-B ignores clkBA", bDriveLow, 8'h12);
    bEnAct = 1'b0; modeBA = 2'b01; bExt = 8'hA5; settle(); pulseBA();
    chk("R3 B-to-A load on clkBA", aOut, 8'h5A);
    bExt = 8'h00; settle();
    chk("R3 B-to-A hold between edges", aOut, 8'h5A);
    pulseAB();
    chk("R3 B-to-A ignores clkAB", aOut, 8'h5A);
  endtask

  task automatic test_latch();
    modeAB = 2'b10; modeBA = 2'b00; bEnAct = 1'b1; bEnInh = 1'b0; bExt = 8'hFF;
    clkAB = 1'b1; aIn = 8'h0F; settle();
    chk("R4 A-to-B open follows", bDriveLow, 8'h0F);
    aIn = 8'hF0; settle();
    chk("R4 A-to-B open follows again", bDriveLow, 8'hF0);
    clkAB = 1'b0; settle(); aIn = 8'h55; settle();
    chk("R4 A-to-B closed holds", bDriveLow, 8'hF0);
    bEnAct = 1'b0; modeBA = 2'b10; clkBA = 1'b1; bExt = 8'h33; settle();
    chk("R4 B-to-A open follows", aOut, 8'hCC);
    clkBA = 1'b0; settle(); bExt = 8'h44; settle();
    chk("R4 B-to-A closed holds", aOut, 8'hCC);
  endtask

  task automatic test_loopback();
    loopback = 1'b1; modeAB = 2'b01; modeBA = 2'b00; bEnAct = 1'b0; bExt = 8'h00;
    aIn = 8'h6B; settle(); pulseAB();
    chk("R5 loop through register", aOut, 8'h94);
    modeBA = 2'b01; settle(); pulseBA();
    aIn = 8'h01; settle(); pulseAB();
    chk("R5 loop B-to-A register holds", aOut, 8'h94);
    modeBA = 2'b00; settle();
    chk("R5 loop buffer shows new word", aOut, 8'hFE);
    modeAB = 2'b00; aIn = 8'hC3; bExt = 8'h3C; settle();
    chk("R5 loop ignores bus", aOut, 8'h3C);
    loopback = 1'b0; settle();
  endtask

  task automatic test_enables();
    oeA = 1'b0; settle();
    chk("R6 aOutEn off", aOutEn, 8'h00);
    oeA = 1'b1; settle();
    chk("R6 aOutEn on", aOutEn, 8'hFF);
    modeAB = 2'b01; bEnAct = 1'b0; aIn = 8'hC7; settle(); pulseAB();
    chk("R9 B disabled no pull", bDriveLow, 8'h00);
    bEnAct = 1'b1; settle();
    chk("R9 B stored while disabled", bDriveLow, 8'hC7);
    bEnAct = 1'b0; oeA = 1'b0; modeBA = 2'b01; loopback = 1'b0; bExt = 8'h2D; settle();
    pulseBA();
    chk("R9 A disabled enable low", aOutEn, 8'h00);
    oeA = 1'b1; settle();
    chk("R9 A stored while disabled", aOut, 8'hD2);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    test_reset();
    test_buffer();
    test_b_enables();
    test_register();
    test_latch();
    test_loopback();
    test_enables();
    finishRun();
  end

  int wdCount = 0;
  always @(posedge clk) begin
    wdCount <= wdCount + 1;
    if (wdCount > 100000 && !done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual %0d expected %0d", wdCount, 100000);
      finishRun();
    end
  end

endmodule